// File: doc/BRIEF.md
# Header-Then-Payload Byte Transmitter

This block sits on the transmit side of a byte-wide link. A source raises a valid strobe to start a transfer. The block first places a one-byte status header on its transmit bus and holds it there until the sink raises a ready strobe. One further cycle of header follows, and then the source's data word passes straight through to the bus until the source drops valid.

The header code depends on the live data input. A zero word produces 0x40 and any nonzero word produces 0xC0. A three-state controller (idle, active, end) with a one-cycle hold flag sequences the transfer. If the source withdraws valid before ready arrives, the block aborts. If ready never arrives, a configurable timeout ends the transfer and raises a sticky error flag, which a write-one input clears.

By default the bus is decoded combinationally from the registered state and the live data input. A parameter selects a registered bus instead. In that mode the value is computed from the next state at each edge, so state-driven changes appear in the same cycles as in the combinational mode.

Top module: `hdr_tx`

## Requirements
- R1: While the active-low asynchronous reset is asserted, and in the first cycle after it is released, the controller is idle, the bus is 0x00 and both abort and error flags are low.
- R2: In idle the bus is 0x00. A rising edge with valid high moves the controller to active, and ready is ignored while idle. With valid low it stays idle.
- R3: In active the bus carries 0x40 when the live data input is 0x00 and 0xC0 for any other data value.
- R4: The controller stays in active, driving the header, until ready is sampled high together with valid. It then enters end with the hold flag set, and the header is driven for that one extra cycle.
- R5: In end, after the hold cycle, the bus equals the live data input every cycle. When valid is sampled low in end, the controller returns to idle.
- R6: If valid is sampled low in active, the controller returns to idle and the abort flag is high for exactly the following cycle. This check takes priority over ready.
- R7: After TIMEOUT_CYC consecutive active cycles with valid high and ready low, the controller returns to idle and the error flag goes high. The flag then stays high.
- R8: A high clear input at an edge lowers the error flag, unless a timeout happens at that same edge, in which case the flag is set.
- R9: With REG_OUT=1, the bus after each edge equals the combinational decode of the new state and hold flag, using the data value sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_vld | input | 1 | Source valid strobe |
| snk_rdy | input | 1 | Sink ready strobe |
| din | input | W | Source data word |
| err_clr | input | 1 | Write-one clear of the error flag |
| tx_bus | output | W | Transmit bus |
| abort_pulse | output | 1 | One-cycle flag after an abandoned header phase |
| timeout_err | output | 1 | Sticky timeout error flag |

## Verification
The hardest situation to reach from the ports is the timeout. Random valid and ready strobes almost never leave the controller in active for TIMEOUT_CYC cycles in a row. A directed sequence therefore holds valid high with ready low for longer than the limit, and then tries the clear input both alone and alongside a second timeout.

Other directed sequences cover:
- ready arriving in the same cycle as valid, which must be ignored in idle;
- a valid drop during the hold cycle;
- back-to-back transfers separated by a single idle cycle.

A second instance built with the registered bus runs on the same stimulus, so the two decode options are compared cycle by cycle against one reference model.

// File: rtl/hdr_tx.sv
`timescale 1ns/1ps
module hdr_tx #(
  parameter int W           = 8,
  parameter logic [W-1:0] HDR_ZERO = 8'h40,
  parameter logic [W-1:0] HDR_DATA = 8'hC0,
  parameter int TIMEOUT_CYC = 16,
  parameter bit REG_OUT     = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         src_vld,
  input  logic         snk_rdy,
  input  logic [W-1:0] din,
  input  logic         err_clr,
  output logic [W-1:0] tx_bus,
  output logic         abort_pulse,
  output logic         timeout_err
);
  localparam int CW = $clog2(TIMEOUT_CYC) + 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(TIMEOUT_CYC - 1);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_ACT = 2'd1, S_FIN = 2'd2} st_t;

  st_t st, st_n;
  logic hold, hold_n;
  logic [CW-1:0] cnt, cnt_n;
  logic abort_n, to_hit;

  function automatic logic [W-1:0] decode(st_t s, logic h, logic [W-1:0] d);
    logic [W-1:0] hdr;
    hdr = (d == '0) ? HDR_ZERO : HDR_DATA;
    decode = '0;
    case (s)
      S_ACT:   decode = hdr;
      S_FIN:   decode = h ? hdr : d;
      default: decode = '0;
    endcase
  endfunction

  always_comb begin
    st_n    = st;
    hold_n  = 1'b0;
    cnt_n   = cnt;
    abort_n = 1'b0;
    to_hit  = 1'b0;
    case (st)
      S_IDLE: if (src_vld) begin
        st_n  = S_ACT;
        cnt_n = '0;
      end
      S_ACT: begin
        if (!src_vld) begin
          st_n    = S_IDLE;
          abort_n = 1'b1;
        end else if (snk_rdy) begin
          st_n   = S_FIN;
          hold_n = 1'b1;
        end else if (cnt == CNT_LAST) begin
          st_n   = S_IDLE;
          to_hit = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      S_FIN: if (!src_vld) st_n = S_IDLE;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      hold        <= 1'b0;
      cnt         <= '0;
      abort_pulse <= 1'b0;
      timeout_err <= 1'b0;
    end else begin
      st          <= st_n;
      hold        <= hold_n;
      cnt         <= cnt_n;
      abort_pulse <= abort_n;
      if (to_hit)       timeout_err <= 1'b1;
      else if (err_clr) timeout_err <= 1'b0;
    end
  end

  generate
    if (REG_OUT) begin : g_reg
      logic [W-1:0] bus_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= '0;
        else        bus_q <= decode(st_n, hold_n, din);
      end
      assign tx_bus = bus_q;
    end else begin : g_comb
      assign tx_bus = decode(st, hold, din);
    end
  endgenerate
endmodule

// File: rtl/hdr_tx_chk.sv
`timescale 1ns/1ps
module hdr_tx_chk #(
  parameter int W = 8,
  parameter logic [W-1:0] HDR_ZERO = 8'h40,
  parameter logic [W-1:0] HDR_DATA = 8'hC0,
  parameter bit REG_OUT = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   st,
  input logic         hold,
  input logic         src_vld,
  input logic         snk_rdy,
  input logic [W-1:0] din,
  input logic         err_clr,
  input logic [W-1:0] tx_bus,
  input logic         abort_pulse,
  input logic         timeout_err
);
  p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT == 1'b0 && st == 2'd0) |-> tx_bus == '0);

  p_idle_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && !src_vld) |=> st == 2'd0);

  p_hdr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT == 1'b0 && st == 2'd1) |-> tx_bus == ((din == '0) ? HDR_ZERO : HDR_DATA));

  p_hold_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && src_vld && snk_rdy) |=> (hold && st == 2'd2));

  p_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT == 1'b0 && st == 2'd2 && !hold) |-> tx_bus == din);

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && !src_vld) |=> (abort_pulse && st == 2'd0));

  p_abort_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout_err && !err_clr) |=> timeout_err);
endmodule

bind hdr_tx hdr_tx_chk #(
  .W(W), .HDR_ZERO(HDR_ZERO), .HDR_DATA(HDR_DATA), .REG_OUT(REG_OUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st(st), .hold(hold), .src_vld(src_vld),
  .snk_rdy(snk_rdy), .din(din), .err_clr(err_clr), .tx_bus(tx_bus),
  .abort_pulse(abort_pulse), .timeout_err(timeout_err)
);

// File: tb/hdr_tx_tb.sv
`timescale 1ns/1ps
module hdr_tx_tb;
  localparam int TO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0, rdy = 1'b0, clr = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] bus_c, bus_r;
  logic ab_c, ab_r, er_c, er_r;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hdr_tx #(.TIMEOUT_CYC(TO), .REG_OUT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .src_vld(vld), .snk_rdy(rdy), .din(din),
    .err_clr(clr), .tx_bus(bus_c), .abort_pulse(ab_c), .timeout_err(er_c));

  hdr_tx #(.TIMEOUT_CYC(TO), .REG_OUT(1'b1)) u_dut_r (
    .clk(clk), .rst_n(rst_n), .src_vld(vld), .snk_rdy(rdy), .din(din),
    .err_clr(clr), .tx_bus(bus_r), .abort_pulse(ab_r), .timeout_err(er_r));

  // reference model: 0 idle, 1 active, 2 end
  int m_st = 0;
  bit m_hold = 0;
  int m_cnt = 0;
  bit m_ab = 0, m_err = 0;
  logic [7:0] m_rbus = 8'h00;

  function automatic logic [7:0] ebus(int s, bit h, logic [7:0] d);
    logic [7:0] hdr = (d == 8'h00) ? 8'h40 : 8'hC0;
    if (s == 1) return hdr;
    if (s == 2) return h ? hdr : d;
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string bus_tag();
    if (m_st == 0) return "R2 idle bus";
    if (m_st == 1) return "R3 header";
    if (m_hold)    return "R4 hold header";
    return "R5 passthrough";
  endfunction

  task automatic model_step();
    int ns = m_st; bit nh = 0; int nc = m_cnt; bit ab = 0; bit to = 0;
    case (m_st)
      0: if (vld) begin ns = 1; nc = 0; end
      1: if (!vld) begin ns = 0; ab = 1; end
         else if (rdy) begin ns = 2; nh = 1; end
         else if (m_cnt == TO - 1) begin ns = 0; to = 1; end
         else nc = m_cnt + 1;
      default: if (!vld) ns = 0;
    endcase
    m_rbus = ebus(ns, nh, din);
    m_st = ns; m_hold = nh; m_cnt = nc; m_ab = ab;
    if (to) m_err = 1;
    else if (clr) m_err = 0;
  endtask

  task automatic cyc(bit v, bit r, logic [7:0] d, bit c);
    @(negedge clk);
    vld = v; rdy = r; din = d; clr = c;
    #1;
    chk(bus_tag(), bus_c, ebus(m_st, m_hold, din));
    chk("R9 registered bus", bus_r, m_rbus);
    chk("R6 abort flag", {7'd0, ab_c}, {7'd0, m_ab});
    chk("R6 abort flag reg", {7'd0, ab_r}, {7'd0, m_ab});
    chk(clr ? "R8 error flag" : "R7 error flag", {7'd0, er_c}, {7'd0, m_err});
    model_step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #3;
    chk("R1 reset bus", bus_c, 8'h00);
    chk("R1 reset bus reg", bus_r, 8'h00);
    chk("R1 reset abort", {7'd0, ab_c}, 8'h00);
    chk("R1 reset err", {7'd0, er_c}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 1, 8'h55, 0);
    // ready together with valid in idle, zero data
    cyc(1, 1, 8'h00, 0);
    cyc(1, 1, 8'h00, 0);
    cyc(1, 0, 8'h12, 0);
    cyc(1, 0, 8'h34, 0);
    cyc(0, 0, 8'h56, 0);
    // back-to-back with header wait
    cyc(1, 0, 8'h07, 0);
    cyc(1, 0, 8'h00, 0);
    cyc(1, 1, 8'h09, 0);
    cyc(1, 0, 8'hA5, 0);
    cyc(0, 0, 8'h00, 0);
    cyc(1, 0, 8'h01, 0);
    // early valid drop -> abort
    cyc(0, 1, 8'h01, 0);
    cyc(0, 0, 8'h00, 0);
    // valid drop during the hold cycle
    cyc(1, 0, 8'h03, 0);
    cyc(1, 1, 8'h03, 0);
    cyc(0, 0, 8'h03, 0);
    cyc(0, 0, 8'h03, 0);
    // timeout
    for (int i = 0; i < TO + 4; i++) cyc(1, 0, 8'(i), 0);
    cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 1);
    cyc(0, 0, 8'h00, 0);
    // timeout coinciding with clear: set wins
    for (int i = 0; i < TO; i++) cyc(1, 0, 8'hF0, 0);
    cyc(1, 0, 8'hF0, 1);
    cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit v = ($urandom_range(0, 9) < 8);
      bit r = ($urandom_range(0, 9) < 2);
      bit c = ($urandom_range(0, 19) == 0);
      logic [7:0] d = ($urandom_range(0, 2) == 0) ? 8'h00 : 8'($urandom);
      cyc(v, r, d, c);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule